// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Read Cache Lookup

This block is the lookup stage of a small read-only level-one data cache. It holds 16 KB of data in 32-byte lines arranged as 128 sets of 4 ways. Because the set index and the byte offset both lie inside the 12-bit page offset, these bits are the same in the virtual and the physical address. The block therefore reads the tags of a set as soon as a request is accepted, while address translation still runs elsewhere. Only the tag compare waits for the 20-bit physical page number.

A request carries a 32-bit virtual address. In a later cycle the translation side presents the physical page number with a strobe. On a hit the block returns the addressed 32-bit word. On a miss it raises a line request to the next level and waits for a 256-bit refill. It installs that line in a victim way and then completes the read from the refill data. A flush input drops every line in one cycle. Only one request is handled at a time, and a ready output shows when a new one is accepted.

Top module: `vipt_lookup`

## Requirements
- R1: After reset, reqReady is 1 and rdValid, rdHit and missValid are 0. All lines are invalid.
- R2: The set index is reqVaddr[11:5] and the word is selected by reqVaddr[4:2]. When the strobe's xlatPpn equals the stored tag of a valid way in that set, rdValid and rdHit are 1 in the cycle after the strobe cycle. rdData is then bits [32*word +: 32] of that line.
- R3: On a lookup miss, missValid rises in the cycle after the strobe cycle, with missLineAddr = {xlatPpn, index}. Both hold unchanged, with rdValid at 0, until a refill is taken.
- R4: refillValid is taken while missValid is 1. In the next cycle rdValid is 1, rdHit is 0, missValid is 0, and rdData is bits [32*word +: 32] of refillData. The line is then resident.
- R5: Only the physical page number decides a hit. Virtual address bits [31:12] are ignored, and a different page number for the same index misses.
- R6: A refill fills the lowest-numbered invalid way of the set. If every way is valid, it replaces the way chosen by a 3-bit tree pseudo-LRU. Node 1 chooses between the way pairs {0,1} and {2,3}, with 0 meaning the lower pair. Nodes 2 and 3 choose within each pair. Every hit and every fill points the nodes on its path away from the way it used.
- R7: A flush makes every resident line invalid, so later lookups miss.
- R8: A flush in the same cycle as the translation strobe forces that lookup to miss.
- R9: When a flush and a refill fall in the same cycle, the refilled line stays valid and all other lines are dropped.
- R10: The translation strobe is ignored unless a lookup waits for it. A refill is ignored unless a miss is pending. A stray strobe or refill produces no rdValid and installs no line.
- R11: reqReady is 1 only while idle. It falls in the cycle after a request is accepted and returns in the cycle the result is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all lines |
| reqValid | input | 1 | Read request strobe |
| reqVaddr | input | 32 | Virtual address of the read |
| reqReady | output | 1 | Block is idle and takes a request |
| xlatValid | input | 1 | Physical page number is valid |
| xlatPpn | input | 20 | Physical page number from translation |
| rdValid | output | 1 | Read result is valid |
| rdHit | output | 1 | Result came from a resident line |
| rdData | output | 32 | Read word |
| missValid | output | 1 | Line request to the next level |
| missLineAddr | output | 27 | Physical line address of the request |
| refillValid | input | 1 | Refill line is present |
| refillData | input | 256 | Refill line, word 0 in the low bits |

## Verification
Flush can fall in the same cycle as either of the two state-changing events, the tag decision and the line install. The bench drives each pairing on purpose. A flush raised together with the translation strobe for a resident line must turn the expected hit into a miss with a correct line request. A flush raised together with the refill must leave only that refilled line resident. This second case is judged by a later hit on the refilled address and a miss on a line that was resident before.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_MISS = 2'd2
  } lookupStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch index/word and read set tags
    logic decide;    // compare tags against the page number
    logic install;   // write refill line into victim way
    logic clearAll;  // drop all valid bits
  } ctrlStrobesT;

endpackage

// File: rtl/vipt_control.sv
module vipt_control
  import vipt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        flush,
  input  logic        reqValid,
  input  logic        xlatValid,
  input  logic        refillValid,
  input  logic        lookupHit,
  output ctrlStrobesT ctrl,
  output logic        reqReady,
  output logic        rdValid,
  output logic        rdHit,
  output logic        missValid
);

  lookupStateT state, stateNext;
  logic rdValidQ, rdHitQ;

  always_comb begin
    ctrl.capture  = (state == ST_IDLE) && reqValid;
    ctrl.decide   = (state == ST_WAIT) && xlatValid;
    ctrl.install  = (state == ST_MISS) && refillValid;
    ctrl.clearAll = flush;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) stateNext = ST_WAIT;
      ST_WAIT: if (xlatValid) stateNext = lookupHit ? ST_IDLE : ST_MISS;
      ST_MISS: if (refillValid) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rdValidQ <= 1'b0;
      rdHitQ   <= 1'b0;
    end else begin
      state    <= stateNext;
      rdValidQ <= (ctrl.decide && lookupHit) || ctrl.install;
      rdHitQ   <= ctrl.decide && lookupHit;
    end
  end

  assign reqReady  = (state == ST_IDLE);
  assign missValid = (state == ST_MISS);
  assign rdValid   = rdValidQ;
  assign rdHit     = rdHitQ;

  // R3: no read result while a line request is outstanding
  p_miss_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    missValid |-> !rdValid);

  // R11: an accepted request makes the block busy
  p_busy_after_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R4: a taken refill completes the read as a non-hit
  p_refill_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && refillValid) |=> (rdValid && !rdHit && !missValid));

  // R2: a hit is always reported with a valid result
  p_hit_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdHit |-> rdValid);

  // R10: a strobe outside a waiting lookup gives no result
  p_stray_xlat_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !reqValid && xlatValid) |=> !rdValid);

endmodule

// File: rtl/vipt_datapath.sv
module vipt_datapath
  import vipt_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PPN_W      = 20,
  parameter int SETS       = 128,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(SETS),
  localparam int WAY_W     = $clog2(WAYS),
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int WSEL_W    = OFF_W - 2,
  localparam int LADDR_W   = PPN_W + IDX_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobesT        ctrl,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic [PPN_W-1:0]   xlatPpn,
  input  logic [LINE_W-1:0]  refillData,
  output logic               lookupHit,
  output logic [31:0]        rdData,
  output logic [LADDR_W-1:0] missLineAddr
);

  localparam int SLOTS = SETS * WAYS;

  // storage
  logic [PPN_W-1:0]  tagMem  [SLOTS];
  logic [LINE_W-1:0] dataMem [SLOTS];
  logic [WAYS-1:0]   validMem [SETS];
  logic [WAYS-2:0]   plruMem  [SETS];

  // request-cycle capture
  logic [IDX_W-1:0]  idxQ;
  logic [WSEL_W-1:0] wordQ;
  logic [PPN_W-1:0]  setTagQ [WAYS];
  logic [WAYS-1:0]   setValidQ;
  logic [31:0]       rdDataQ;
  logic [LADDR_W-1:0] missAddrQ;

  logic [IDX_W-1:0]  reqIdx;
  logic [WSEL_W-1:0] reqWord;
  logic [WAYS-1:0]   hitVec;
  logic [WAY_W-1:0]  hitWay;
  logic [WAY_W-1:0]  victimWay;
  logic              unusedVaBits;

  assign reqIdx       = reqVaddr[OFF_W +: IDX_W];
  assign reqWord      = reqVaddr[OFF_W-1:2];
  assign unusedVaBits = ^{reqVaddr[VA_W-1:OFF_W+IDX_W], reqVaddr[1:0]};

  function automatic logic [WAY_W-1:0] plruVictim(input logic [WAYS-2:0] tree);
    int node = 1;
    for (int lvl = 0; lvl < WAY_W; lvl++)
      node = 2 * node + int'(tree[node-1]);
    return WAY_W'(node - WAYS);
  endfunction

  function automatic logic [WAYS-2:0] plruTouch(input logic [WAYS-2:0] tree,
                                                input logic [WAY_W-1:0] way);
    logic [WAYS-2:0] t = tree;
    int node = 1;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      t[node-1] = ~way[WAY_W-1-lvl];
      node = 2 * node + int'(way[WAY_W-1-lvl]);
    end
    return t;
  endfunction

  function automatic logic [31:0] pickWord(input logic [LINE_W-1:0] ln,
                                           input logic [WSEL_W-1:0] sel);
    return ln[32*sel +: 32];
  endfunction

  // parallel tag compare, one comparator per way
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hitVec[g] = setValidQ[g] && (setTagQ[g] == xlatPpn);
  end

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (hitVec[w]) hitWay = WAY_W'(w);
  end

  assign lookupHit = (|hitVec) && !ctrl.clearAll;

  // invalid way first (lowest index), otherwise tree pseudo-LRU
  always_comb begin
    victimWay = plruVictim(plruMem[idxQ]);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!validMem[idxQ][w]) victimWay = WAY_W'(w);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        plruMem[s]  <= '0;
      end
      for (int w = 0; w < WAYS; w++) setTagQ[w] <= '0;
      idxQ      <= '0;
      wordQ     <= '0;
      setValidQ <= '0;
      rdDataQ   <= '0;
      missAddrQ <= '0;
    end else begin
      if (ctrl.capture) begin
        idxQ      <= reqIdx;
        wordQ     <= reqWord;
        setValidQ <= ctrl.clearAll ? '0 : validMem[reqIdx];
        for (int w = 0; w < WAYS; w++)
          setTagQ[w] <= tagMem[{reqIdx, WAY_W'(w)}];
      end else if (ctrl.clearAll) begin
        setValidQ <= '0;
      end

      if (ctrl.decide) begin
        if (lookupHit) begin
          rdDataQ       <= pickWord(dataMem[{idxQ, hitWay}], wordQ);
          plruMem[idxQ] <= plruTouch(plruMem[idxQ], hitWay);
        end else begin
          missAddrQ <= {xlatPpn, idxQ};
        end
      end

      if (ctrl.clearAll)
        for (int s = 0; s < SETS; s++) validMem[s] <= '0;

      if (ctrl.install) begin
        validMem[idxQ][victimWay] <= 1'b1;
        plruMem[idxQ]             <= plruTouch(plruMem[idxQ], victimWay);
        rdDataQ                   <= pickWord(refillData, wordQ);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.install) begin
      tagMem[{idxQ, victimWay}]  <= missAddrQ[IDX_W +: PPN_W];
      dataMem[{idxQ, victimWay}] <= refillData;
    end
  end

  assign rdData       = rdDataQ;
  assign missLineAddr = missAddrQ;

  // R2: tags within a set never match the same page twice
  p_single_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R6: the filled way is valid afterwards, even under a flush (R9)
  p_fill_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.install |=> validMem[$past(idxQ)][$past(victimWay)]);

  // R7: a flush alone leaves the current set empty
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.clearAll && !ctrl.install) |=> (validMem[$past(idxQ)] == '0));

  // R8: no hit is reported when a flush meets the decision
  p_flush_decide_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.decide && ctrl.clearAll) |=> (setValidQ == '0));

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PPN_W      = 20,
  parameter int SETS       = 128,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 32,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int LADDR_W   = PPN_W + $clog2(SETS)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               reqValid,
  input  logic [VA_W-1:0]    reqVaddr,
  output logic               reqReady,
  input  logic               xlatValid,
  input  logic [PPN_W-1:0]   xlatPpn,
  output logic               rdValid,
  output logic               rdHit,
  output logic [31:0]        rdData,
  output logic               missValid,
  output logic [LADDR_W-1:0] missLineAddr,
  input  logic               refillValid,
  input  logic [LINE_W-1:0]  refillData
);

  ctrlStrobesT ctrl;
  logic        lookupHit;

  vipt_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .flush      (flush),
    .reqValid   (reqValid),
    .xlatValid  (xlatValid),
    .refillValid(refillValid),
    .lookupHit  (lookupHit),
    .ctrl       (ctrl),
    .reqReady   (reqReady),
    .rdValid    (rdValid),
    .rdHit      (rdHit),
    .missValid  (missValid)
  );

  vipt_datapath #(
    .VA_W      (VA_W),
    .PPN_W     (PPN_W),
    .SETS      (SETS),
    .WAYS      (WAYS),
    .LINE_BYTES(LINE_BYTES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .reqVaddr    (reqVaddr),
    .xlatPpn     (xlatPpn),
    .refillData  (refillData),
    .lookupHit   (lookupHit),
    .rdData      (rdData),
    .missLineAddr(missLineAddr)
  );

  // R3: the line request stays steady until serviced
  p_miss_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && $past(missValid)) |-> $stable(missLineAddr));

endmodule

// File: tb/tb_vipt_lookup.sv
`timescale 1ns/1ps
module tb_vipt_lookup;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         flush = 1'b0;
  logic         reqValid = 1'b0;
  logic [31:0]  reqVaddr = '0;
  logic         reqReady;
  logic         xlatValid = 1'b0;
  logic [19:0]  xlatPpn = '0;
  logic         rdValid, rdHit;
  logic [31:0]  rdData;
  logic         missValid;
  logic [26:0]  missLineAddr;
  logic         refillValid = 1'b0;
  logic [255:0] refillData = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vipt_lookup dut (
    .clk(clk), .rstN(rstN), .flush(flush),
    .reqValid(reqValid), .reqVaddr(reqVaddr), .reqReady(reqReady),
    .xlatValid(xlatValid), .xlatPpn(xlatPpn),
    .rdValid(rdValid), .rdHit(rdHit), .rdData(rdData),
    .missValid(missValid), .missLineAddr(missLineAddr),
    .refillValid(refillValid), .refillData(refillData)
  );

  function automatic logic [31:0] patWord(input logic [26:0] la, input logic [2:0] w);
    return {w, la, 2'b00};
  endfunction

  function automatic logic [255:0] patLine(input logic [26:0] la);
    logic [255:0] ln;
    for (int w = 0; w < 8; w++) ln[32*w +: 32] = patWord(la, 3'(w));
    return ln;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One read: request, strobe, then hit check or miss/refill checks.
  task automatic lookup(input logic [31:0] va, input logic [19:0] ppn, input bit expHit,
                        input bit flushDec, input bit flushRef, input string tag);
    logic [26:0] la = {ppn, va[11:5]};
    logic [31:0] expW = patWord(la, va[4:2]);
    @(negedge clk);
    check(reqReady == 1'b1, {"R11 idle ready ", tag}, 64'(reqReady), 1);
    reqValid = 1'b1; reqVaddr = va;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, {"R11 busy ", tag}, 64'(reqReady), 0);
    xlatValid = 1'b1; xlatPpn = ppn; flush = flushDec;
    @(negedge clk);
    xlatValid = 1'b0; flush = 1'b0;
    if (expHit) begin
      check(rdValid && rdHit && !missValid, {"R2 hit flags ", tag},
            64'({rdValid, rdHit, missValid}), 64'b110);
      check(rdData == expW, {"R2 hit data ", tag}, 64'(rdData), 64'(expW));
      check(reqReady == 1'b1, {"R11 ready at result ", tag}, 64'(reqReady), 1);
    end else begin
      check(missValid && !rdValid, {"R3 miss raised ", tag},
            64'({missValid, rdValid}), 64'b10);
      check(missLineAddr == la, {"R3 line addr ", tag}, 64'(missLineAddr), 64'(la));
      @(negedge clk);
      check(missValid && !rdValid && missLineAddr == la, {"R3 held ", tag},
            64'(missLineAddr), 64'(la));
      refillValid = 1'b1; refillData = patLine(la); flush = flushRef;
      @(negedge clk);
      refillValid = 1'b0; flush = 1'b0;
      check(rdValid && !rdHit && !missValid, {"R4 refill flags ", tag},
            64'({rdValid, rdHit, missValid}), 64'b100);
      check(rdData == expW, {"R4 refill data ", tag}, 64'(rdData), 64'(expW));
    end
  endtask

  task automatic t_reset();
    check(reqReady == 1'b1, "R1 reqReady", 64'(reqReady), 1);
    check(!rdValid && !rdHit && !missValid, "R1 outputs low",
          64'({rdValid, rdHit, missValid}), 0);
  endtask

  task automatic t_basic();
    lookup(32'h0000_1A44, 20'h12345, 0, 0, 0, "cold");
    for (int k = 0; k < 8; k++)
      lookup(32'h0000_1A40 + 32'(4*k), 20'h12345, 1, 0, 0, "word sweep R2");
  endtask

  task automatic t_tag_only();
    // R5: upper VA bits differ, page number same -> hit
    lookup(32'h7777_7A48, 20'h12345, 1, 0, 0, "R5 va upper ignored");
    // R5: same index, other page -> miss
    lookup(32'h0000_1A48, 20'h54321, 0, 0, 0, "R5 other page");
    lookup(32'h0000_1A48, 20'h12345, 1, 0, 0, "R5 first page kept");
  endtask

  task automatic t_plru();
    // R6: index 0x10 fills ways 0..3 with pages 0x100..0x103.
    for (int p = 0; p < 4; p++)
      lookup(32'h0000_0200, 20'h00100 + 20'(p), 0, 0, 0, "R6 fill");
    // after fills all nodes 0; hit way0 -> node1=1,node2=1; victim is way2
    lookup(32'h0000_0204, 20'h00100, 1, 0, 0, "R6 touch way0");
    lookup(32'h0000_0208, 20'h00104, 0, 0, 0, "R6 fifth page");
    lookup(32'h0000_020C, 20'h00100, 1, 0, 0, "R6 way0 kept");
    lookup(32'h0000_0210, 20'h00101, 1, 0, 0, "R6 way1 kept");
    lookup(32'h0000_0214, 20'h00103, 1, 0, 0, "R6 way3 kept");
    lookup(32'h0000_0218, 20'h00104, 1, 0, 0, "R6 new resident");
    lookup(32'h0000_021C, 20'h00102, 0, 0, 0, "R6 way2 evicted");
  endtask

  task automatic t_stray();
    @(negedge clk);
    xlatValid = 1'b1; xlatPpn = 20'h0BEEF;
    refillValid = 1'b1; refillData = patLine({20'h0BEEF, 7'h18});
    @(negedge clk);
    xlatValid = 1'b0; refillValid = 1'b0;
    check(!rdValid && !missValid && reqReady, "R10 stray strobes no effect",
          64'({rdValid, missValid, reqReady}), 64'b001);
    lookup(32'h0000_0300, 20'h0BEEF, 0, 0, 0, "R10 stray refill not installed");
  endtask

  task automatic t_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    lookup(32'h0000_1A44, 20'h12345, 0, 0, 0, "R7 after flush");
    // R8: flush with the strobe on a resident line
    lookup(32'h0000_1A44, 20'h12345, 0, 1, 0, "R8 flush at decision");
    lookup(32'h0000_1A44, 20'h12345, 1, 0, 0, "R8 refilled afterwards");
  endtask

  task automatic t_flush_refill();
    lookup(32'h0000_0A80, 20'h22222, 0, 0, 0, "R9 setup X");
    lookup(32'h0000_0C00, 20'h33333, 0, 0, 1, "R9 flush with refill");
    lookup(32'h0000_0C04, 20'h33333, 1, 0, 0, "R9 refilled line kept");
    lookup(32'h0000_0A84, 20'h22222, 0, 0, 0, "R9 other line dropped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_tag_only();
    t_plru();
    t_stray();
    t_flush();
    t_flush_refill();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule